// File: doc/BRIEF.md
# AUX Request and Reply Framer

This block turns one sideband channel transaction into its request byte stream and turns the bytes that come back into a reply verdict. A request is started with a one-cycle pulse that carries a 4-bit command, a 20-bit address, a transfer length of 0 to 16 bytes and, for write commands, the payload bytes. The block packs a three- or four-byte header, appends the payload when the command writes, and sends the bytes one at a time on a valid/ready byte port. It also reports how many bytes the request holds.

On the reply side the receiver hands over all received bytes at once, with a received-byte count and a hot-plug-loss flag, in a one-cycle pulse. One cycle later the block reports the reply code, an error class and the number of data bytes it accepted. On an acknowledged read it copies the data bytes into a read buffer. Bit coding, preamble generation and the analog transceiver sit outside this block.

Top module: `aux_msg_framer`

## Requirements
- R1: Header byte 0 is {command[3:0], address[19:16]}. Byte 1 is address[15:8]. Byte 2 is address[7:0].
- R2: When the length is nonzero, byte 3 is length minus one. A zero-length request has a three-byte header.
- R3: Only the write commands 4'b1000, 4'b0000 and 4'b0100 are followed by payload bytes, in ascending index order (byte k is req_wdata[8k+7:8k]). tx_total is the header size plus the length for those commands and the header size alone for all others. It is valid from the cycle after the accepted start.
- R4: tx_valid rises the cycle after an accepted start. tx_byte stays stable while tx_valid is high and tx_ready is low. req_done pulses for one cycle right after the last byte is accepted, and tx_valid is then low.
- R5: A req_start while req_busy is high is ignored. The stream in progress and tx_total are unchanged.
- R6: Reply results appear together with a one-cycle rep_done pulse, one cycle after rep_valid. A count of zero gives rep_err=1 (invalid), rep_code=0 and data count 0, and the read buffer is unchanged.
- R7: rep_code is bits 7:4 of the first received byte. A nonzero code gives rep_err=0 and data count 0, and the read buffer is unchanged.
- R8: With code 0 (ACK), the data count is the received count minus one. Read-buffer byte k takes received byte k+1 for k below that count, and the higher buffer bytes are unchanged.
- R9: If the received count minus one exceeds the length of the most recently accepted request, the result is rep_err=2 (overflow) with data count 0, and the read buffer is unchanged.
- R10: hpd_lost high with rep_valid gives rep_err=3, rep_code=0 and data count 0, whatever the other inputs. The read buffer is unchanged.
- R11: After reset tx_valid, req_busy, req_done and rep_done are low, rep_err and the data count are 0, and the read buffer is all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_start | input | 1 | Start pulse for a request |
| req_cmd | input | 4 | Command nibble |
| req_addr | input | 20 | Target address |
| req_len | input | 5 | Transfer length, 0 to 16 |
| req_wdata | input | 128 | Payload bytes, byte k at bits 8k+7:8k |
| tx_ready | input | 1 | Downstream accepts the byte |
| tx_valid | output | 1 | Byte on tx_byte is valid |
| tx_byte | output | 8 | Request byte |
| tx_total | output | 5 | Byte count of the current request |
| req_busy | output | 1 | Request in progress |
| req_done | output | 1 | Last request byte accepted |
| rep_valid | input | 1 | Reply bytes and count present |
| rep_count | input | 5 | Number of received bytes |
| rep_bytes | input | 136 | Received bytes, byte k at bits 8k+7:8k |
| hpd_lost | input | 1 | Sink disconnected during the reply |
| rep_done | output | 1 | Reply verdict updated |
| rep_code | output | 4 | Reply code nibble |
| rep_err | output | 2 | 0 ok, 1 invalid, 2 overflow, 3 disconnect |
| rep_data_count | output | 5 | Data bytes accepted into the buffer |
| rd_buf | output | 128 | Read buffer, byte k at bits 8k+7:8k |

## Verification
The in-module properties watch, on every cycle, the things that hold at any time: the byte stays stable under backpressure, done follows a handshake, a start while busy leaves the latched request alone, and the error classes keep a zero data count and a frozen buffer. Only the bench's scenarios can show that the byte values and order match the header packing for each command and length, that tx_total is right, and that ACK data lands in the right buffer slots while the others keep older contents. Randomized requests and replies mixed with directed zero-length, full-length, overflow-by-one and disconnect cases cover these.

// File: rtl/aux_msg_pkg.sv
// Shared types for the AUX message framer.
// Assumes: command nibble encodings as listed in the brief.
package aux_msg_pkg;
    localparam int ADDR_W = 20;
    localparam int CMD_W  = 4;

    typedef enum logic [1:0] {
        REP_OK        = 2'd0,
        REP_INVALID   = 2'd1,
        REP_OVERFLOW  = 2'd2,
        REP_UNPLUGGED = 2'd3
    } rep_err_e;

    // True for the three commands that carry a payload
    function automatic logic cmd_carries_payload(input logic [CMD_W-1:0] c);
        return (c == 4'h8) || (c[3] == 1'b0 && c[1:0] == 2'b00);
    endfunction
endpackage

// File: rtl/aux_req_tx.sv
// Request serializer: latches one request on an idle start, then emits
// header and payload bytes on a valid/ready port.
// Assumes: len never exceeds MAX_LEN.
module aux_req_tx
    import aux_msg_pkg::*;
#(
    parameter int MAX_LEN = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [CMD_W-1:0]         cmd,
    input  logic [ADDR_W-1:0]        addr,
    input  logic [$clog2(MAX_LEN+1)-1:0] len,
    input  logic [MAX_LEN*8-1:0]     wdata,
    input  logic                     tx_ready,
    output logic                     tx_valid,
    output logic [7:0]               tx_byte,
    output logic [$clog2(MAX_LEN+5)-1:0] tx_total,
    output logic                     busy,
    output logic                     done,
    output logic [$clog2(MAX_LEN+1)-1:0] len_held
);
    localparam int LEN_W  = $clog2(MAX_LEN + 1);
    localparam int TOT_W  = $clog2(MAX_LEN + 5);
    localparam int PIDX_W = (MAX_LEN > 1) ? $clog2(MAX_LEN) : 1;

    logic [CMD_W-1:0]  cmd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [7:0]        pay_q [MAX_LEN];
    logic [TOT_W-1:0]  idx_q, total_q, hdr_q, hdr_n, total_n;
    logic [PIDX_W-1:0] pidx;
    logic              busy_q, done_q;

    // Size of the incoming request
    always_comb begin
        hdr_n   = (len != '0) ? TOT_W'(4) : TOT_W'(3);
        total_n = hdr_n + (cmd_carries_payload(cmd) ? TOT_W'(len) : TOT_W'(0));
    end

    // Control: accept on idle start, step the index on each handshake
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_q   <= '0;
            addr_q  <= '0;
            len_q   <= '0;
            idx_q   <= '0;
            total_q <= '0;
            busy_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (!busy_q && start) begin
                cmd_q   <= cmd;
                addr_q  <= addr;
                len_q   <= len;
                idx_q   <= '0;
                total_q <= total_n;
                busy_q  <= 1'b1;
            end else if (busy_q && tx_ready) begin
                if (idx_q == total_q - TOT_W'(1)) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end else begin
                    idx_q <= idx_q + TOT_W'(1);
                end
            end
        end
    end

    // Payload capture, one register byte per slot
    for (genvar g = 0; g < MAX_LEN; g++) begin : g_pay
        always_ff @(posedge clk) begin
            if (!rst_n)
                pay_q[g] <= '0;
            else if (!busy_q && start)
                pay_q[g] <= wdata[g*8 +: 8];
        end
    end

    // Byte selection by position in the stream
    always_comb begin
        hdr_q = (len_q != '0) ? TOT_W'(4) : TOT_W'(3);
        pidx  = PIDX_W'(idx_q - hdr_q);
        if (idx_q == TOT_W'(0))
            tx_byte = {cmd_q, addr_q[19:16]};
        else if (idx_q == TOT_W'(1))
            tx_byte = addr_q[15:8];
        else if (idx_q == TOT_W'(2))
            tx_byte = addr_q[7:0];
        else if (idx_q == TOT_W'(3) && len_q != '0)
            tx_byte = 8'(len_q) - 8'd1;
        else
            tx_byte = pay_q[pidx];
    end

    assign tx_valid = busy_q;
    assign tx_total = total_q;
    assign busy     = busy_q;
    assign done     = done_q;
    assign len_held = len_q;

    // R4
    tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid && !tx_ready |=> tx_valid && $stable(tx_byte));
    // R4
    done_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> $past(busy_q && tx_ready) && !busy_q);
    // R5
    busy_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q && start |=> $stable(total_q) && $stable(len_q) && $stable(addr_q));
    // R3
    total_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |-> total_q >= TOT_W'(3) && total_q <= TOT_W'(MAX_LEN + 4));
endmodule

// File: rtl/aux_rep_rx.sv
// Reply parser: judges a received reply in one cycle and copies
// acknowledged read data into the read buffer.
// Assumes: rep_bytes holds at least as many bytes as rep_count names,
// up to MAX_LEN+1.
module aux_rep_rx
    import aux_msg_pkg::*;
#(
    parameter int MAX_LEN = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          rep_valid,
    input  logic [$clog2(MAX_LEN+2)-1:0]  rep_count,
    input  logic [(MAX_LEN+1)*8-1:0]      rep_bytes,
    input  logic                          hpd_lost,
    input  logic [$clog2(MAX_LEN+1)-1:0]  req_len,
    output logic                          done,
    output logic [CMD_W-1:0]              code,
    output rep_err_e                      err,
    output logic [$clog2(MAX_LEN+2)-1:0]  data_count,
    output logic [MAX_LEN*8-1:0]          rd_buf
);
    localparam int CNT_W = $clog2(MAX_LEN + 2);

    logic [7:0]       head;
    logic [CNT_W-1:0] n_data, cnt_n, cnt_q;
    logic [CMD_W-1:0] code_n, code_q;
    rep_err_e         err_n, err_q;
    logic             wr_en, done_q;
    logic [7:0]       buf_q [MAX_LEN];

    // Verdict for the reply on the inputs, checks in priority order
    always_comb begin
        head   = rep_bytes[7:0];
        n_data = rep_count - CNT_W'(1);
        code_n = '0;
        cnt_n  = '0;
        wr_en  = 1'b0;
        err_n  = REP_OK;
        if (hpd_lost) begin
            err_n = REP_UNPLUGGED;
        end else if (rep_count == '0) begin
            err_n = REP_INVALID;
        end else if (head >= 8'h10) begin
            code_n = head[7:4];
        end else if (n_data > CNT_W'(req_len)) begin
            err_n = REP_OVERFLOW;
        end else begin
            cnt_n = n_data;
            wr_en = 1'b1;
        end
    end

    // Verdict registers, updated on each reply
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            code_q <= '0;
            err_q  <= REP_OK;
            cnt_q  <= '0;
        end else begin
            done_q <= rep_valid;
            if (rep_valid) begin
                code_q <= code_n;
                err_q  <= err_n;
                cnt_q  <= cnt_n;
            end
        end
    end

    // Read buffer, slot g written only by an accepted ACK that reaches it
    for (genvar g = 0; g < MAX_LEN; g++) begin : g_buf
        always_ff @(posedge clk) begin
            if (!rst_n)
                buf_q[g] <= '0;
            else if (rep_valid && wr_en && CNT_W'(g) < n_data)
                buf_q[g] <= rep_bytes[(g+1)*8 +: 8];
        end
        assign rd_buf[g*8 +: 8] = buf_q[g];
    end

    assign done       = done_q;
    assign code       = code_q;
    assign err        = err_q;
    assign data_count = cnt_q;

    // R7
    code_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && code_q != '0 |-> cnt_q == '0 && err_q == REP_OK && $stable(rd_buf));
    // R9
    overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q && err_q == REP_OVERFLOW |-> cnt_q == '0 && $stable(rd_buf));
    // R10
    unplug_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid && hpd_lost |=> err_q == REP_UNPLUGGED && cnt_q == '0 && $stable(rd_buf));
    // R6
    empty_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rep_valid && !hpd_lost && rep_count == '0 |=> done_q && err_q == REP_INVALID);
    // R8
    ack_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |-> cnt_q <= CNT_W'(MAX_LEN));
endmodule

// File: rtl/aux_msg_framer.sv
// Top of the AUX message framer: request serializer plus reply parser.
// The parser bounds reply data by the length of the last accepted request.
module aux_msg_framer
    import aux_msg_pkg::*;
#(
    parameter int MAX_LEN = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          req_start,
    input  logic [3:0]                    req_cmd,
    input  logic [19:0]                   req_addr,
    input  logic [$clog2(MAX_LEN+1)-1:0]  req_len,
    input  logic [MAX_LEN*8-1:0]          req_wdata,
    input  logic                          tx_ready,
    output logic                          tx_valid,
    output logic [7:0]                    tx_byte,
    output logic [$clog2(MAX_LEN+5)-1:0]  tx_total,
    output logic                          req_busy,
    output logic                          req_done,
    input  logic                          rep_valid,
    input  logic [$clog2(MAX_LEN+2)-1:0]  rep_count,
    input  logic [(MAX_LEN+1)*8-1:0]      rep_bytes,
    input  logic                          hpd_lost,
    output logic                          rep_done,
    output logic [3:0]                    rep_code,
    output logic [1:0]                    rep_err,
    output logic [$clog2(MAX_LEN+2)-1:0]  rep_data_count,
    output logic [MAX_LEN*8-1:0]          rd_buf
);
    localparam int LEN_W = $clog2(MAX_LEN + 1);

    logic [LEN_W-1:0] len_held;
    rep_err_e         err_w;

    aux_req_tx #(.MAX_LEN(MAX_LEN)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (req_start),
        .cmd      (req_cmd),
        .addr     (req_addr),
        .len      (req_len),
        .wdata    (req_wdata),
        .tx_ready (tx_ready),
        .tx_valid (tx_valid),
        .tx_byte  (tx_byte),
        .tx_total (tx_total),
        .busy     (req_busy),
        .done     (req_done),
        .len_held (len_held)
    );

    aux_rep_rx #(.MAX_LEN(MAX_LEN)) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .rep_valid  (rep_valid),
        .rep_count  (rep_count),
        .rep_bytes  (rep_bytes),
        .hpd_lost   (hpd_lost),
        .req_len    (len_held),
        .done       (rep_done),
        .code       (rep_code),
        .err        (err_w),
        .data_count (rep_data_count),
        .rd_buf     (rd_buf)
    );

    assign rep_err = err_w;
endmodule

// File: tb/tb_aux_msg_framer.sv
`timescale 1ns/1ps
module tb_aux_msg_framer;
    localparam int MAXL = 16;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               req_start = 1'b0;
    logic [3:0]         req_cmd = '0;
    logic [19:0]        req_addr = '0;
    logic [4:0]         req_len = '0;
    logic [MAXL*8-1:0]  req_wdata = '0;
    logic               tx_ready = 1'b0;
    logic               tx_valid;
    logic [7:0]         tx_byte;
    logic [4:0]         tx_total;
    logic               req_busy, req_done;
    logic               rep_valid = 1'b0;
    logic [4:0]         rep_count = '0;
    logic [(MAXL+1)*8-1:0] rep_bytes = '0;
    logic               hpd_lost = 1'b0;
    logic               rep_done;
    logic [3:0]         rep_code;
    logic [1:0]         rep_err;
    logic [4:0]         rep_data_count;
    logic [MAXL*8-1:0]  rd_buf;

    int checks = 0;
    int errors = 0;
    int last_len = 0;
    logic [MAXL*8-1:0] model_buf = '0;

    always #10 clk = ~clk;

    aux_msg_framer #(.MAX_LEN(MAXL)) dut (.*);

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic bit carries(input logic [3:0] c);
        return (c == 4'h8) || (c == 4'h0) || (c == 4'h4);
    endfunction

    function automatic int exp_total(input logic [3:0] c, input int len);
        return (len != 0 ? 4 : 3) + (carries(c) ? len : 0);
    endfunction

    function automatic logic [7:0] exp_byte(input logic [3:0] c, input logic [19:0] a,
                                            input int len, input logic [MAXL*8-1:0] wd,
                                            input int i);
        int hdr = (len != 0) ? 4 : 3;
        if (i == 0) return {c, a[19:16]};
        if (i == 1) return a[15:8];
        if (i == 2) return a[7:0];
        if (i == 3 && len != 0) return 8'(len - 1);
        return wd[(i - hdr)*8 +: 8];
    endfunction

    task automatic run_req(input logic [3:0] c, input logic [19:0] a, input int len,
                           input logic [MAXL*8-1:0] wd, input bit poke);
        int tot, got, guard;
        string tag;
        @(negedge clk);
        req_cmd = c; req_addr = a; req_len = 5'(len); req_wdata = wd; req_start = 1'b1;
        @(negedge clk);
        req_start = 1'b0;
        last_len = len;
        tot = exp_total(c, len);
        chk(tx_total == 5'(tot), "R3", "tx_total", tx_total, tot);
        chk(tx_valid && req_busy, "R4", "valid after start", {tx_valid, req_busy}, 2'b11);
        got = 0; guard = 0;
        while (got < tot && guard < 2000) begin
            bit r = ($urandom % 4) != 0;
            tx_ready = r;
            if (poke && got == 1) begin
                req_start = 1'b1; req_cmd = ~c; req_addr = ~a; req_len = 5'((len + 5) % 17);
            end else begin
                req_start = 1'b0;
            end
            if (tx_valid && r) begin
                logic [7:0] e = exp_byte(c, a, len, wd, got);
                if (got < 3) tag = "R1";
                else if (got == 3 && len != 0) tag = "R2";
                else tag = "R3";
                if (poke) tag = "R5";
                chk(tx_byte == e, tag, $sformatf("byte %0d", got), tx_byte, e);
                got++;
            end
            @(negedge clk);
            guard++;
        end
        tx_ready = 1'b0; req_start = 1'b0;
        chk(got == tot, "R4", "bytes sent", got, tot);
        chk(req_done && !tx_valid && !req_busy, "R4", "done after last",
            {req_done, tx_valid, req_busy}, 3'b100);
        if (poke) chk(tx_total == 5'(tot), "R5", "total kept", tx_total, tot);
        @(negedge clk);
        chk(!req_done, "R4", "done one cycle", req_done, 0);
    endtask

    task automatic run_rep(input int cnt, input logic [(MAXL+1)*8-1:0] rb, input bit hpd);
        int e_err, e_code, e_cnt;
        string tag;
        @(negedge clk);
        rep_valid = 1'b1; rep_count = 5'(cnt); rep_bytes = rb; hpd_lost = hpd;
        @(negedge clk);
        rep_valid = 1'b0; hpd_lost = 1'b0;
        e_code = 0; e_cnt = 0;
        if (hpd) begin e_err = 3; tag = "R10"; end
        else if (cnt == 0) begin e_err = 1; tag = "R6"; end
        else if (rb[7:4] != 0) begin e_err = 0; e_code = rb[7:4]; tag = "R7"; end
        else if (cnt - 1 > last_len) begin e_err = 2; tag = "R9"; end
        else begin
            e_err = 0; e_cnt = cnt - 1; tag = "R8";
            for (int k = 0; k < e_cnt; k++) model_buf[k*8 +: 8] = rb[(k+1)*8 +: 8];
        end
        chk(rep_done == 1'b1, "R6", "rep_done", rep_done, 1);
        chk(rep_err == 2'(e_err), tag, "rep_err", rep_err, e_err);
        chk(rep_code == 4'(e_code), tag, "rep_code", rep_code, e_code);
        chk(rep_data_count == 5'(e_cnt), tag, "data count", rep_data_count, e_cnt);
        chk(rd_buf == model_buf, tag, "read buffer", rd_buf, model_buf);
        @(negedge clk);
        chk(!rep_done, "R6", "rep_done one cycle", rep_done, 0);
    endtask

    function automatic logic [MAXL*8-1:0] rnd_wd();
        logic [MAXL*8-1:0] v;
        for (int k = 0; k < MAXL; k++) v[k*8 +: 8] = 8'($urandom);
        return v;
    endfunction

    function automatic logic [(MAXL+1)*8-1:0] rnd_rb(input logic [3:0] code);
        logic [(MAXL+1)*8-1:0] v;
        for (int k = 0; k <= MAXL; k++) v[k*8 +: 8] = 8'($urandom);
        v[7:4] = code;
        return v;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R4 watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [3:0] cmds [8] = '{4'h8, 4'h9, 4'h0, 4'h1, 4'h4, 4'h5, 4'h2, 4'h6};
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(!tx_valid && !req_busy && !req_done && !rep_done, "R11", "idle flags",
            {tx_valid, req_busy, req_done, rep_done}, 0);
        chk(rep_err == 2'd0 && rep_data_count == '0, "R11", "verdict", {rep_err, rep_data_count}, 0);
        chk(rd_buf == '0, "R11", "read buffer", rd_buf, 0);

        // Directed requests: zero and full lengths, reads and writes
        run_req(4'h9, 20'hABCDE, 0, rnd_wd(), 1'b0);
        run_req(4'h9, 20'h00102, 16, rnd_wd(), 1'b0);
        run_req(4'h8, 20'hF0F0F, 1, rnd_wd(), 1'b0);
        run_req(4'h4, 20'h00050, 16, rnd_wd(), 1'b0);
        run_req(4'h0, 20'h00050, 0, rnd_wd(), 1'b0);
        run_req(4'h6, 20'h12345, 0, rnd_wd(), 1'b0);
        run_req(4'h8, 20'h55AA5, 7, rnd_wd(), 1'b1);

        // Directed replies against a 4-byte read
        run_req(4'h9, 20'h00200, 4, rnd_wd(), 1'b0);
        run_rep(5, rnd_rb(4'h0), 1'b0);
        run_rep(2, rnd_rb(4'h0), 1'b0);
        run_rep(6, rnd_rb(4'h0), 1'b0);
        run_rep(0, rnd_rb(4'h0), 1'b0);
        run_rep(3, rnd_rb(4'h1), 1'b0);
        run_rep(5, rnd_rb(4'h2), 1'b0);
        run_rep(5, rnd_rb(4'h0), 1'b1);
        run_rep(1, rnd_rb(4'h0), 1'b0);

        // Random mix
        for (int n = 0; n < 40; n++) begin
            int len = $urandom % 17;
            run_req(cmds[$urandom % 8], 20'($urandom), len, rnd_wd(), ($urandom % 5) == 0);
            run_rep($urandom % 19, rnd_rb(($urandom % 3 == 0) ? 4'($urandom) : 4'h0),
                    ($urandom % 9) == 0);
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule